// File: doc/BRIEF.md
# Flash Array Program/Erase Engine

This block models a byte-wide flash array with its own internal operation timing. A command decoder in front of it issues three kinds of request on one request/acknowledge port: program one byte, erase the whole array, or arm a permanent write protection on the lowest region of the address space (the boot region). Programs and erases run for a fixed number of clock cycles, counted internally, and the host never has to step them.

Reads use a separate strobe-driven port. When the engine is idle, a read returns the stored byte. While an operation is running, a read returns a status word instead of data. The host polls that status word to find out when the operation has finished. Storage follows flash rules. The erased state is all ones. A program can only clear bits. Once the boot region is protected, that protection survives every command and every reset.

Top module: `flash_engine`

## Requirements
- R1: After reset, `busy`, `done`, `op_ack` and `rd_valid` are 0. Before any lock command has been issued, `boot_locked` is 0.
- R2: A program of data D to address A leaves the old content of A AND D. The array powers up erased, with every byte all ones.
- R3: An accepted program keeps `busy` high for PROG_CYC cycles (minimum 2). An accepted erase keeps `busy` high for the larger of ERASE_CYC and the array depth. `done` pulses for exactly one cycle on the cycle `busy` falls.
- R4: A request presented while `busy` is high gets no `op_ack` and has no effect. `op_ack` follows an accepted request by one cycle.
- R5: A read during a program returns the complement of bit 7 of the data being programmed on bit 7, and 0 on bits 5..0.
- R6: During a program or erase, bit 6 of successive read results alternates between 0 and 1. Once the operation completes, reads return the true stored byte.
- R7: Erase (`op_kind` = 1) sets every byte to 8'hFF. During an erase, bit 7 and bits 5..0 of a read result are 0.
- R8: The lock command (`op_kind` = 2) sets `boot_locked` in the cycle after it is accepted. No command and no reset clears it.
- R9: While `boot_locked` is 1, a program (`op_kind` = 0) to an address whose bits above BOOT_W are all zero is acknowledged but ignored: `busy` stays low, no `done` pulse follows, and the byte is unchanged. Programs outside that region still work.
- R10: While `boot_locked` is 1, an erase leaves every boot-region byte unchanged and sets all other bytes to 8'hFF.
- R11: A read strobe sampled at one rising edge makes `rd_valid` high, with the result on `rd_data`, after the second rising edge from that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not clear the lock) |
| op_req | input | 1 | Operation request |
| op_kind | input | 2 | 0 program, 1 erase, 2 lock boot region, 3 no operation |
| op_addr | input | ADDR_W | Program address |
| op_data | input | DATA_W | Program data |
| op_ack | output | 1 | Request accepted (one-cycle pulse) |
| busy | output | 1 | Program or erase in progress |
| done | output | 1 | One-cycle pulse when an operation finishes |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read result, stored byte or status word |
| rd_valid | output | 1 | `rd_data` holds a new result |
| boot_locked | output | 1 | Boot region protection is active |

## Verification
On every cycle, the assertions check the following:
- no acknowledge is given to a request that arrives while busy;
- `done` only ends a busy period;
- the lock bit never falls;
- no array write lands in the boot region while the lock is set;
- the operation counter stays within its limit;
- every sampled read strobe produces a valid result.

The values themselves can only be shown by the bench's scenarios. These are the AND-only program result across full sweeps of the array, the status word fields and the alternating bit 6 during both operation kinds, the exact operation lengths, and the preservation of boot bytes through a locked erase and a reset.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_LOCK  = 2'd2,
    OP_NOP   = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2
  } eng_state_e;
endpackage

// File: rtl/flash_mem.sv
module flash_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] arr [DEPTH];

  // power-up content is the erased state
  initial begin
    for (int i = 0; i < DEPTH; i++) arr[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
    q <= arr[raddr];
  end
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_eng_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int BOOT_W    = 7,
  parameter int PROG_CYC  = 3000,
  parameter int ERASE_CYC = 1000000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_req,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  output logic              op_ack,
  output logic              busy,
  output logic              done,
  output logic              is_prog,
  output logic              prog_msb,
  output logic              locked,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] mem_q,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int PROG_LEN  = (PROG_CYC > 2) ? PROG_CYC : 2;
  localparam int ERASE_LEN = (ERASE_CYC > DEPTH) ? ERASE_CYC : DEPTH;
  localparam int LIMIT     = (PROG_LEN > ERASE_LEN) ? PROG_LEN : ERASE_LEN;
  localparam int CW        = $clog2(LIMIT + 1);

  function automatic logic in_boot(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BOOT_W] == '0;
  endfunction

  eng_state_e        state;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;
  logic              lock_q = 1'b0;
  logic              accept, last, sweeping;
  logic [ADDR_W-1:0] sweep_addr;

  assign accept     = op_req && (state == ST_IDLE);
  assign sweep_addr = cnt[ADDR_W-1:0];
  assign sweeping   = cnt < CW'(DEPTH);
  assign last       = (state == ST_PROG)  ? (cnt == CW'(PROG_LEN - 1)) :
                      (state == ST_ERASE) ? (cnt == CW'(ERASE_LEN - 1)) : 1'b0;

  // program: read-modify-write through the shared read port, write on last cycle
  // erase: one byte per cycle during the first DEPTH cycles of the window
  assign mem_raddr = (state == ST_PROG) ? cur_addr : rd_addr;
  assign mem_we    = ((state == ST_PROG) && last) ||
                     ((state == ST_ERASE) && sweeping && !(lock_q && in_boot(sweep_addr)));
  assign mem_waddr = (state == ST_ERASE) ? sweep_addr : cur_addr;
  assign mem_wdata = (state == ST_ERASE) ? '1 : (mem_q & cur_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cur_addr <= '0;
      cur_data <= '0;
      op_ack   <= 1'b0;
      done     <= 1'b0;
    end else begin
      op_ack <= accept;
      done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cnt <= '0;
            if (op_kind == OP_PROG && !(lock_q && in_boot(op_addr))) begin
              state    <= ST_PROG;
              cur_addr <= op_addr;
              cur_data <= op_data;
            end else if (op_kind == OP_ERASE) begin
              state <= ST_ERASE;
            end
          end
        end
        default: begin
          if (last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      endcase
    end
  end

  // protection bit models a nonvolatile cell: reset leaves it alone
  always_ff @(posedge clk) begin
    if (accept && op_kind == OP_LOCK) lock_q <= 1'b1;
  end

  assign busy     = (state != ST_IDLE);
  assign is_prog  = (state == ST_PROG);
  assign prog_msb = cur_data[DATA_W-1];
  assign locked   = lock_q;

  a_r4_no_ack_while_busy: assert property (@(posedge clk) disable iff (rst)
    op_ack |-> !$past(busy));
  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(lock_q) |-> lock_q);
  a_r9_boot_write_blocked: assert property (@(posedge clk) disable iff (rst)
    (mem_we && lock_q) |-> !in_boot(mem_waddr));
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CW'(LIMIT)));
endmodule

// File: rtl/flash_rdpath.sv
module flash_rdpath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              busy,
  input  logic              is_prog,
  input  logic              prog_msb,
  input  logic [DATA_W-1:0] mem_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              s1_valid, s1_stat, tog;
  logic [DATA_W-1:0] s1_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_stat  <= 1'b0;
      s1_word  <= '0;
      tog      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      s1_valid <= rd_stb;
      if (rd_stb) begin
        s1_stat <= busy;
        s1_word <= {(is_prog ? ~prog_msb : 1'b0), tog, {(DATA_W-2){1'b0}}};
        if (busy) tog <= ~tog;
      end
      rd_valid <= s1_valid;
      if (s1_valid) rd_data <= s1_stat ? s1_word : mem_q;
    end
  end

  a_r11_read_completes: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> rd_valid);
endmodule

// File: rtl/flash_engine.sv
module flash_engine #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int BOOT_W    = 7,
  parameter int PROG_CYC  = 3000,
  parameter int ERASE_CYC = 1000000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_req,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  output logic              op_ack,
  output logic              busy,
  output logic              done,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              boot_locked
);
  logic              is_prog, prog_msb, mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_q;

  flash_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_W(BOOT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .op_req(op_req), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .op_ack(op_ack), .busy(busy), .done(done),
    .is_prog(is_prog), .prog_msb(prog_msb), .locked(boot_locked),
    .rd_addr(rd_addr), .mem_q(mem_q),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_raddr(mem_raddr)
  );

  flash_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .q(mem_q)
  );

  flash_rdpath #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .busy(busy),
    .is_prog(is_prog), .prog_msb(prog_msb), .mem_q(mem_q),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/sim_flash_engine.sv
module sim_flash_engine;
  localparam int AW = 6, DW = 8, BW = 3, PC = 6, EC = 80;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic op_req = 1'b0, rd_stb = 1'b0;
  logic [1:0] op_kind = '0;
  logic [AW-1:0] op_addr = '0, rd_addr = '0;
  logic [DW-1:0] op_data = '0;
  logic op_ack, busy, done, rd_valid, boot_locked;
  logic [DW-1:0] rd_data;

  int nchk = 0, nfail = 0, cyc = 0, cyc_a = 0;
  bit finished = 0;
  logic [DW-1:0] model [DEPTH];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_engine #(.ADDR_W(AW), .DATA_W(DW), .BOOT_W(BW), .PROG_CYC(PC), .ERASE_CYC(EC)) u0 (
    .clk(clk), .rst(rst), .op_req(op_req), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .op_ack(op_ack), .busy(busy), .done(done),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .boot_locked(boot_locked)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_op(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic ack);
    @(negedge clk);
    op_req = 1'b1; op_kind = k; op_addr = a; op_data = d;
    tick();
    ack = op_ack; cyc_a = cyc;
    @(negedge clk);
    op_req = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_stb = 1'b1; rd_addr = a;
    tick();
    @(negedge clk);
    rd_stb = 1'b0;
    tick();
    check("R11 rd_valid", {31'b0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic wait_idle(output int dur, output logic dn);
    while (busy) tick();
    dur = cyc - cyc_a; dn = done;
  endtask

  function automatic logic [DW-1:0] pat1(input int a);
    return DW'((a * 37 + 11) ^ 8'h5A);
  endfunction
  function automatic logic [DW-1:0] pat2(input int a);
    return DW'((a * 13) ^ 8'hC3);
  endfunction

  task automatic read_all(input string tag);
    logic [DW-1:0] d;
    for (int a = 0; a < DEPTH; a++) begin
      rd(AW'(a), d);
      check(tag, {24'b0, d}, {24'b0, model[a]});
    end
  endtask

  task automatic prog_all(input bit second);
    logic ack, dn;
    logic [DW-1:0] d, s1, s2;
    int dur;
    for (int a = 0; a < DEPTH; a++) begin
      d = second ? pat2(a) : pat1(a);
      do_op(2'd0, AW'(a), d, ack);
      check("R4 ack program", {31'b0, ack}, 32'd1);
      if (a == 5) begin
        rd(AW'(a), s1);
        rd(AW'(a), s2);
        check("R5 poll bit7", {31'b0, s1[7]}, {31'b0, ~d[7]});
        check("R5 poll low bits", {26'b0, s1[5:0]}, 32'd0);
        check("R6 toggle program", {31'b0, s2[6]}, {31'b0, ~s1[6]});
      end
      wait_idle(dur, dn);
      model[a] = model[a] & d;
      if (a < 3) begin
        check("R3 program length", dur, PC);
        check("R3 done pulse", {31'b0, dn}, 32'd1);
        tick();
        check("R3 done one cycle", {31'b0, done}, 32'd0);
      end
    end
  endtask

  task automatic erase_op(input string tag);
    logic ack, dn;
    logic [DW-1:0] s [4];
    int dur;
    do_op(2'd1, '0, '0, ack);
    check({tag, " ack"}, {31'b0, ack}, 32'd1);
    for (int i = 0; i < 4; i++) rd(AW'(i), s[i]);
    for (int i = 0; i < 4; i++) begin
      check("R7 erase poll bit7/low", {24'b0, s[i] & 8'hBF}, 32'd0);
      if (i > 0) check("R6 toggle erase", {31'b0, s[i][6]}, {31'b0, ~s[i-1][6]});
    end
    wait_idle(dur, dn);
    check("R3 erase length", dur, EC);
    check("R3 erase done", {31'b0, dn}, 32'd1);
    for (int a = 0; a < DEPTH; a++)
      if (!(boot_locked && (a >> BW) == 0)) model[a] = '1;
  endtask

  initial begin
    logic ack, dn;
    logic [DW-1:0] d;
    int dur;
    for (int a = 0; a < DEPTH; a++) model[a] = '1;
    repeat (3) tick();
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 done", {31'b0, done}, 0);
    check("R1 ack", {31'b0, op_ack}, 0);
    check("R1 rd_valid", {31'b0, rd_valid}, 0);
    check("R1 locked", {31'b0, boot_locked}, 0);
    @(negedge clk); rst = 1'b0;
    read_all("R2 erased power-up");

    erase_op("R7");
    read_all("R7 erased");

    prog_all(1'b0);
    read_all("R2 first program");
    prog_all(1'b1);
    read_all("R2 AND program");

    // R4: request while busy is refused
    do_op(2'd0, AW'(40), 8'h00, ack);
    model[40] = 8'h00;
    do_op(2'd1, '0, '0, ack);
    check("R4 refused ack", {31'b0, ack}, 0);
    wait_idle(dur, dn);
    tick();
    check("R4 refused no busy", {31'b0, busy}, 0);
    read_all("R4 nothing erased");

    // R8 lock
    do_op(2'd2, '0, '0, ack);
    check("R8 lock ack", {31'b0, ack}, 1);
    check("R8 locked", {31'b0, boot_locked}, 1);
    check("R8 lock not busy", {31'b0, busy}, 0);

    // R9 boot program ignored, outside still works
    do_op(2'd0, AW'(3), 8'h00, ack);
    check("R9 ack", {31'b0, ack}, 1);
    check("R9 no busy", {31'b0, busy}, 0);
    tick();
    check("R9 no done", {31'b0, done}, 0);
    rd(AW'(3), d);
    check("R9 boot unchanged", {24'b0, d}, {24'b0, model[3]});
    do_op(2'd0, AW'(20), 8'h00, ack);
    wait_idle(dur, dn);
    model[20] = 8'h00;
    rd(AW'(20), d);
    check("R9 outside programmed", {24'b0, d}, 0);

    // R10 locked erase
    erase_op("R10");
    read_all("R10 boot kept");
    check("R8 lock after erase", {31'b0, boot_locked}, 1);

    @(negedge clk); rst = 1'b1;
    tick(); tick();
    check("R8 lock through reset", {31'b0, boot_locked}, 1);
    check("R1 busy after reset", {31'b0, busy}, 0);
    @(negedge clk); rst = 1'b0;
    read_all("R10 boot kept after reset");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule